// File: doc/BRIEF.md
# Floppy Controller Host Register Interface

This block is the processor-facing side of a controller for up to four floppy drives. The host reaches it through a small byte-wide register window. Through that window it picks a drive, a side and the motor state, sets track and sector numbers, and issues commands. It reads back status and moves sector data one byte at a time through a data register. Each drive keeps its own track, sector, byte counter and BUSY/DRQ flags, so switching drives does not disturb a transfer that is under way on another drive.

On the media side the block drives a plain byte-addressed storage port. A read command copies one 256-byte sector from storage into a local sector buffer. The host then drains the buffer through the data register. A write command opens the buffer for 256 host writes, and the filled buffer is then committed to storage. Seek and restore only change the track register. Media presence and write protection arrive per drive as inputs.

Top module: `fdc_host_regs`

## Requirements
- R1: Register offsets on bus_addr_i: 0 is drive select, 4 is command (write) / status (read), 5 is track, 6 is sector, 7 is data. Offsets 1 to 3 read as zero. After reset the selected drive is 0, every track is 0, every sector is 1, and every byte counter stands at 256 (no transfer open).
- R2: A write to offset 0 selects the drive from bits [1:0] and drives side_o from bit 6. Bit 7 set raises motor_on_o for MOTOR_TICKS cycles, and each new write with bit 7 set restarts that window.
- R3: A read of offset 0 returns bit 7 = interrupt pending and bit 6 = DRQ of the selected drive, other bits zero. The interrupt is raised when a byte counter reaches 256 or when a seek or restore executes. It is cleared by a status read or by an accepted read or write command.
- R4: The status byte holds bit 0 BUSY, bit 1 DRQ, bit 6 write protect (media_wp_i of the selected drive) and bit 7 not ready (media_present_i of the selected drive low).
- R5: A status read returns 0x02 instead of 0x03 when the value returned by the previous status read was 0x00. Every status read records the value it returned; after reset that record is 0x80.
- R6: Command 0x8C or 0x9C sets BUSY and clears the byte counter, then copies the addressed sector from storage into the buffer. DRQ rises 256 cycles after the command; the host then reads bytes 0 to 255 in order from offset 7.
- R7: Command 0xAC on a drive that is not write protected sets BUSY and DRQ at once and clears the byte counter. On a protected drive it changes nothing, and no storage write follows.
- R8: Each data-register access with the counter below 256 moves one byte and advances the selected drive's counter. On reaching 256 BUSY and DRQ clear. After a write command the 256 buffered bytes are then written to storage.
- R9: With the counter at 256, data reads return 0 and data writes are not buffered.
- R10: The storage address of byte i is (track * 72 + sector - 1) * 256 + i, drive-relative, with stor_drive_o naming the drive.
- R11: Command 0x18 or 0x1B loads the track register with the last byte written to offset 7. Command 0x0B sets the track to 0. Both clear BUSY and DRQ.
- R12: Writing 0 to the sector register stores 1.
- R13: Track, sector, byte counter and flags are held separately for each drive.
- R14: On a drive with no media every command is ignored, and unknown command codes change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the access cycle |
| media_present_i | input | NUM_DRIVES | Media present per drive |
| media_wp_i | input | NUM_DRIVES | Write protect per drive |
| side_o | output | 1 | Side select |
| motor_on_o | output | 1 | Motor one-shot output |
| stor_req_o | output | 1 | Storage access this cycle |
| stor_we_o | output | 1 | Storage write (else read) |
| stor_drive_o | output | $clog2(NUM_DRIVES) | Drive of the storage access |
| stor_addr_o | output | ADDR_W | Byte address within the drive |
| stor_wdata_o | output | 8 | Storage write data |
| stor_rdata_i | input | 8 | Storage read data, same cycle |

## Verification
A byte counter that is off by one shows up at the first data read after DRQ as a wrong byte, and a wrong sector base shows up there too, before any flag moves. A flag or interrupt held in the wrong drive's slot shows at the next status or drive-select read after a drive change. A lost or extra commit shows at the storage port, and then as mismatched bytes when the sector is read back through a fresh read command.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  localparam logic [2:0] OFF_DSEL = 3'd0;
  localparam logic [2:0] OFF_CMD  = 3'd4;
  localparam logic [2:0] OFF_TRK  = 3'd5;
  localparam logic [2:0] OFF_SEC  = 3'd6;
  localparam logic [2:0] OFF_DATA = 3'd7;

  localparam logic [7:0] CMD_RD_A   = 8'h8C;
  localparam logic [7:0] CMD_RD_B   = 8'h9C;
  localparam logic [7:0] CMD_WR     = 8'hAC;
  localparam logic [7:0] CMD_SEEK_A = 8'h18;
  localparam logic [7:0] CMD_SEEK_B = 8'h1B;
  localparam logic [7:0] CMD_HOME   = 8'h0B;

  localparam int ST_BUSY  = 0;
  localparam int ST_DRQ   = 1;
  localparam int ST_WPROT = 6;
  localparam int ST_NRDY  = 7;

  typedef enum logic [1:0] {ENG_IDLE, ENG_FILL, ENG_COMMIT} eng_state_e;
endpackage

// File: rtl/fdc_motor_oneshot.sv
module fdc_motor_oneshot #(
  parameter int unsigned TICKS = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic on_o
);
  localparam int CW = $clog2(TICKS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (trig_i)           cnt_q <= CW'(TICKS);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign on_o = (cnt_q != '0);
endmodule

// File: rtl/fdc_sector_buf.sv
module fdc_sector_buf #(
  parameter int unsigned DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [7:0]    rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [7:0]    rdata_b_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];
endmodule

// File: rtl/fdc_offset_calc.sv
module fdc_offset_calc #(
  parameter int unsigned SECT_BYTES    = 256,
  parameter int unsigned SECTS_PER_TRK = 72,
  parameter int unsigned ADDR_W        = 24
) (
  input  logic [7:0]        track_i,
  input  logic [7:0]        sector_i,
  output logic [ADDR_W-1:0] base_o
);
  localparam int SHIFT = $clog2(SECT_BYTES);
  logic [ADDR_W-1:0] lin;

  // sector numbering starts at 1
  assign lin    = ADDR_W'(track_i) * ADDR_W'(SECTS_PER_TRK) + ADDR_W'(sector_i) - ADDR_W'(1);
  assign base_o = lin << SHIFT;
endmodule

// File: rtl/fdc_xfer_engine.sv
module fdc_xfer_engine
  import fdc_pkg::*;
#(
  parameter int unsigned SECT_BYTES = 256,
  parameter int unsigned ADDR_W     = 24,
  localparam int IDX_W = $clog2(SECT_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_fill_i,
  input  logic              start_commit_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              busy_o,
  output logic              stor_req_o,
  output logic              stor_we_o,
  output logic [ADDR_W-1:0] stor_addr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              fill_we_o,
  output logic              fill_done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SECT_BYTES - 1);

  eng_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
    end else begin
      unique case (state_q)
        ENG_IDLE: begin
          idx_q <= '0;
          if (start_fill_i) begin
            state_q <= ENG_FILL;
            base_q  <= base_i;
          end else if (start_commit_i) begin
            state_q <= ENG_COMMIT;
            base_q  <= base_i;
          end
        end
        default: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST) state_q <= ENG_IDLE;
        end
      endcase
    end
  end

  assign busy_o      = (state_q != ENG_IDLE);
  assign stor_req_o  = busy_o;
  assign stor_we_o   = (state_q == ENG_COMMIT);
  assign stor_addr_o = base_q + ADDR_W'(idx_q);
  assign idx_o       = idx_q;
  assign fill_we_o   = (state_q == ENG_FILL);
  assign fill_done_o = fill_we_o && (idx_q == LAST);
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
  import fdc_pkg::*;
#(
  parameter int unsigned NUM_DRIVES    = 4,
  parameter int unsigned SECT_BYTES    = 256,
  parameter int unsigned SECTS_PER_TRK = 72,
  parameter int unsigned ADDR_W        = 24,
  parameter int unsigned MOTOR_TICKS   = 1000000
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          bus_sel_i,
  input  logic                          bus_we_i,
  input  logic [2:0]                    bus_addr_i,
  input  logic [7:0]                    bus_wdata_i,
  output logic [7:0]                    bus_rdata_o,
  input  logic [NUM_DRIVES-1:0]         media_present_i,
  input  logic [NUM_DRIVES-1:0]         media_wp_i,
  output logic                          side_o,
  output logic                          motor_on_o,
  output logic                          stor_req_o,
  output logic                          stor_we_o,
  output logic [$clog2(NUM_DRIVES)-1:0] stor_drive_o,
  output logic [ADDR_W-1:0]             stor_addr_o,
  output logic [7:0]                    stor_wdata_o,
  input  logic [7:0]                    stor_rdata_i
);
  localparam int DRV_W = $clog2(NUM_DRIVES);
  localparam int IDX_W = $clog2(SECT_BYTES);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(SECT_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SECT_BYTES - 1);

  // per-drive state
  logic [7:0]       track_q  [NUM_DRIVES];
  logic [7:0]       sector_q [NUM_DRIVES];
  logic [CNT_W-1:0] cnt_q    [NUM_DRIVES];
  logic [NUM_DRIVES-1:0] busy_q, drq_q;

  // shared state
  logic [DRV_W-1:0]  sel_q, xfer_drv_q;
  logic              side_q, irq_q, wr_pend_q;
  logic [7:0]        prev_stat_q, last_data_q;
  logic [ADDR_W-1:0] wbase_q;

  // decode
  logic rd, wr, hit_dsel, hit_cmd, hit_trk, hit_sec, hit_data;
  assign rd       = bus_sel_i & ~bus_we_i;
  assign wr       = bus_sel_i &  bus_we_i;
  assign hit_dsel = (bus_addr_i == OFF_DSEL);
  assign hit_cmd  = (bus_addr_i == OFF_CMD);
  assign hit_trk  = (bus_addr_i == OFF_TRK);
  assign hit_sec  = (bus_addr_i == OFF_SEC);
  assign hit_data = (bus_addr_i == OFF_DATA);

  logic present, wprot;
  assign present = media_present_i[sel_q];
  assign wprot   = media_wp_i[sel_q];

  // engine / buffer wiring
  logic              eng_busy, fill_we, fill_done, stor_req, stor_we;
  logic [IDX_W-1:0]  eng_idx;
  logic [ADDR_W-1:0] base_now, eng_base, eng_addr;
  logic [7:0]        buf_host_rd, buf_eng_rd;

  logic [CNT_W-1:0] cnt_sel;
  logic [IDX_W-1:0] host_idx;
  logic xfer_open, data_step, last_step, cmd_ok;
  logic is_read, is_write, is_seek, is_home;
  logic start_fill, start_commit;

  assign cnt_sel   = cnt_q[sel_q];
  assign host_idx  = cnt_sel[IDX_W-1:0];
  assign xfer_open = (cnt_sel < CNT_END);
  assign data_step = bus_sel_i & hit_data & ~eng_busy & xfer_open;
  assign last_step = data_step & (cnt_sel == CNT_LAST);

  assign cmd_ok   = wr & hit_cmd & present & ~eng_busy;
  assign is_read  = (bus_wdata_i == CMD_RD_A) || (bus_wdata_i == CMD_RD_B);
  assign is_write = (bus_wdata_i == CMD_WR) && !wprot;
  assign is_seek  = (bus_wdata_i == CMD_SEEK_A) || (bus_wdata_i == CMD_SEEK_B);
  assign is_home  = (bus_wdata_i == CMD_HOME);

  assign start_fill   = cmd_ok & is_read;
  assign start_commit = last_step & bus_we_i & wr_pend_q;
  assign eng_base     = start_fill ? base_now : wbase_q;

  fdc_offset_calc #(
    .SECT_BYTES(SECT_BYTES), .SECTS_PER_TRK(SECTS_PER_TRK), .ADDR_W(ADDR_W)
  ) u_offset (
    .track_i (track_q[sel_q]),
    .sector_i(sector_q[sel_q]),
    .base_o  (base_now)
  );

  fdc_xfer_engine #(.SECT_BYTES(SECT_BYTES), .ADDR_W(ADDR_W)) u_engine (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_fill_i  (start_fill),
    .start_commit_i(start_commit),
    .base_i        (eng_base),
    .busy_o        (eng_busy),
    .stor_req_o    (stor_req),
    .stor_we_o     (stor_we),
    .stor_addr_o   (eng_addr),
    .idx_o         (eng_idx),
    .fill_we_o     (fill_we),
    .fill_done_o   (fill_done)
  );

  logic             buf_we;
  logic [IDX_W-1:0] buf_waddr;
  logic [7:0]       buf_wdata;
  assign buf_we    = fill_we | (data_step & bus_we_i);
  assign buf_waddr = fill_we ? eng_idx : host_idx;
  assign buf_wdata = fill_we ? stor_rdata_i : bus_wdata_i;

  fdc_sector_buf #(.DEPTH(SECT_BYTES)) u_buf (
    .clk_i    (clk_i),
    .we_i     (buf_we),
    .waddr_i  (buf_waddr),
    .wdata_i  (buf_wdata),
    .raddr_a_i(host_idx),
    .rdata_a_o(buf_host_rd),
    .raddr_b_i(eng_idx),
    .rdata_b_o(buf_eng_rd)
  );

  fdc_motor_oneshot #(.TICKS(MOTOR_TICKS)) u_motor (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(wr & hit_dsel & bus_wdata_i[7]),
    .on_o  (motor_on_o)
  );

  // status composition
  logic [7:0] stat_raw, stat_out;
  always_comb begin
    stat_raw           = '0;
    stat_raw[ST_BUSY]  = busy_q[sel_q];
    stat_raw[ST_DRQ]   = drq_q[sel_q];
    stat_raw[ST_WPROT] = wprot;
    stat_raw[ST_NRDY]  = ~present;
  end
  // DRQ shows alone on the first poll after an idle status
  assign stat_out = (prev_stat_q == 8'h00 && stat_raw == 8'h03) ? 8'h02 : stat_raw;

  always_comb begin
    unique case (bus_addr_i)
      OFF_DSEL: bus_rdata_o = {irq_q, drq_q[sel_q], 6'b0};
      OFF_CMD:  bus_rdata_o = stat_out;
      OFF_TRK:  bus_rdata_o = track_q[sel_q];
      OFF_SEC:  bus_rdata_o = sector_q[sel_q];
      OFF_DATA: bus_rdata_o = (~eng_busy & xfer_open) ? buf_host_rd : 8'h00;
      default:  bus_rdata_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < NUM_DRIVES; d++) begin
        track_q[d]  <= '0;
        sector_q[d] <= 8'd1;
        cnt_q[d]    <= CNT_END;
      end
      busy_q      <= '0;
      drq_q       <= '0;
      sel_q       <= '0;
      xfer_drv_q  <= '0;
      side_q      <= 1'b0;
      irq_q       <= 1'b0;
      wr_pend_q   <= 1'b0;
      prev_stat_q <= 8'h80;
      last_data_q <= '0;
      wbase_q     <= '0;
    end else begin
      if (wr && hit_dsel) begin
        sel_q  <= bus_wdata_i[DRV_W-1:0];
        side_q <= bus_wdata_i[6];
      end
      if (wr && hit_trk)  track_q[sel_q]  <= bus_wdata_i;
      if (wr && hit_sec)  sector_q[sel_q] <= (bus_wdata_i == 8'h00) ? 8'd1 : bus_wdata_i;
      if (wr && hit_data) last_data_q     <= bus_wdata_i;
      if (rd && hit_cmd) begin
        prev_stat_q <= stat_out;
        irq_q       <= 1'b0;
      end

      if (cmd_ok) begin
        if (is_read) begin
          busy_q[sel_q] <= 1'b1;
          drq_q[sel_q]  <= 1'b0;
          cnt_q[sel_q]  <= '0;
          wr_pend_q     <= 1'b0;
          xfer_drv_q    <= sel_q;
          irq_q         <= 1'b0;
        end else if (is_write) begin
          busy_q[sel_q] <= 1'b1;
          drq_q[sel_q]  <= 1'b1;
          cnt_q[sel_q]  <= '0;
          wr_pend_q     <= 1'b1;
          xfer_drv_q    <= sel_q;
          wbase_q       <= base_now;
          irq_q         <= 1'b0;
        end else if (is_seek || is_home) begin
          track_q[sel_q] <= is_home ? 8'h00 : last_data_q;
          busy_q[sel_q]  <= 1'b0;
          drq_q[sel_q]   <= 1'b0;
          irq_q          <= 1'b1;
        end
      end

      if (data_step) cnt_q[sel_q] <= cnt_sel + 1'b1;
      if (last_step) begin
        busy_q[sel_q] <= 1'b0;
        drq_q[sel_q]  <= 1'b0;
        irq_q         <= 1'b1;
        if (bus_we_i) wr_pend_q <= 1'b0;
      end

      if (fill_done) drq_q[xfer_drv_q] <= 1'b1;
    end
  end

  assign side_o       = side_q;
  assign stor_req_o   = stor_req;
  assign stor_we_o    = stor_we;
  assign stor_drive_o = xfer_drv_q;
  assign stor_addr_o  = eng_addr;
  assign stor_wdata_o = buf_eng_rd;
endmodule

// File: rtl/fdc_host_regs_chk.sv
module fdc_host_regs_chk #(
  parameter int unsigned NUM_DRIVES = 4,
  parameter int unsigned SECT_BYTES = 256,
  parameter int unsigned ADDR_W     = 24,
  localparam int DRV_W = $clog2(NUM_DRIVES),
  localparam int CNT_W = $clog2(SECT_BYTES) + 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bus_sel_i,
  input logic                  bus_we_i,
  input logic [2:0]            bus_addr_i,
  input logic [7:0]            bus_wdata_i,
  input logic [7:0]            bus_rdata_o,
  input logic [NUM_DRIVES-1:0] media_present_i,
  input logic                  stor_req_o,
  input logic [ADDR_W-1:0]     stor_addr_o,
  input logic                  eng_busy,
  input logic [CNT_W-1:0]      cnt_sel,
  input logic [NUM_DRIVES-1:0] drq_q,
  input logic [DRV_W-1:0]      sel_q
);
  logic rd;
  assign rd = bus_sel_i && !bus_we_i;

  AST_SECTOR_NEVER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_we_i && bus_addr_i == 3'd6 && bus_wdata_i == 8'h00)
    |=> (!(bus_sel_i && !bus_we_i && bus_addr_i == 3'd6) || bus_rdata_o == 8'd1)); // R12

  AST_DATA_ZERO_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bus_addr_i == 3'd7 && !eng_busy && cnt_sel == CNT_W'(SECT_BYTES))
    |-> bus_rdata_o == 8'h00); // R9

  AST_DSEL_DRQ_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bus_addr_i == 3'd0) |-> (bus_rdata_o[6] == drq_q[sel_q])); // R3

  AST_STOR_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stor_req_o && $past(stor_req_o)) |-> (stor_addr_o == $past(stor_addr_o) + ADDR_W'(1))); // R10

  AST_NOT_READY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bus_addr_i == 3'd4 && !media_present_i[sel_q]) |-> bus_rdata_o[7]); // R14

  AST_HOME_ZEROES_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_we_i && bus_addr_i == 3'd4 && bus_wdata_i == 8'h0B
     && media_present_i[sel_q] && !eng_busy)
    |=> (!(bus_sel_i && !bus_we_i && bus_addr_i == 3'd5) || bus_rdata_o == 8'h00)); // R11
endmodule

bind fdc_host_regs fdc_host_regs_chk #(
  .NUM_DRIVES(NUM_DRIVES), .SECT_BYTES(SECT_BYTES), .ADDR_W(ADDR_W)
) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bus_sel_i      (bus_sel_i),
  .bus_we_i       (bus_we_i),
  .bus_addr_i     (bus_addr_i),
  .bus_wdata_i    (bus_wdata_i),
  .bus_rdata_o    (bus_rdata_o),
  .media_present_i(media_present_i),
  .stor_req_o     (stor_req_o),
  .stor_addr_o    (stor_addr_o),
  .eng_busy       (eng_busy),
  .cnt_sel        (cnt_sel),
  .drq_q          (drq_q),
  .sel_q          (sel_q)
);

// File: tb/fdc_host_regs_tb_top.sv
module fdc_host_regs_tb_top;
  localparam int ADDR_W = 24;
  localparam int TICKS  = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  present = 4'b0111;
  logic [3:0]  wp      = 4'b0010;
  logic        side, motor, stor_req, stor_we;
  logic [1:0]  stor_drive;
  logic [ADDR_W-1:0] stor_addr;
  logic [7:0]  stor_wdata, stor_rdata;

  fdc_host_regs #(.MOTOR_TICKS(TICKS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .media_present_i(present), .media_wp_i(wp),
    .side_o(side), .motor_on_o(motor),
    .stor_req_o(stor_req), .stor_we_o(stor_we), .stor_drive_o(stor_drive),
    .stor_addr_o(stor_addr), .stor_wdata_o(stor_wdata), .stor_rdata_i(stor_rdata)
  );

  int checks = 0, errors = 0, wr_cnt = 0;
  bit done = 0;

  // storage model: pattern unless written
  logic [7:0] mem [int];
  function automatic logic [7:0] pat(input int d, input int a);
    return 8'(a + 3 * (a >> 8) + 5 * (a >> 16) + 17 * d);
  endfunction
  function automatic logic [7:0] stor_model(input logic [1:0] d, input logic [ADDR_W-1:0] a);
    int k;
    k = int'({d, a});
    if (mem.exists(k)) return mem[k];
    return pat(int'(d), int'(a));
  endfunction
  assign stor_rdata = stor_model(stor_drive, stor_addr);

  always @(posedge clk) if (stor_req && stor_we) begin
    mem[int'({stor_drive, stor_addr})] = stor_wdata;
    wr_cnt++;
  end

  function automatic int sect_addr(input int trk, input int sec, input int i);
    return (trk * 72 + sec - 1) * 256 + i;
  endfunction

  // scoreboard
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always @(negedge clk) if (rst_n && bus_sel && !bus_we) begin
    logic [7:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if (bus_rdata !== e) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
    end
  end

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic check(input int act, input int exp, input string t);
    @(negedge clk);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 R4 reset state
    rd(3'd4, 8'h00, "R4 status after reset");
    rd(3'd5, 8'h00, "R1 track after reset");
    rd(3'd6, 8'h01, "R1 sector after reset");
    rd(3'd0, 8'h00, "R3 drive select after reset");
    rd(3'd7, 8'h00, "R9 data with no transfer");
    rd(3'd1, 8'h00, "R1 unused offset");

    // R12 sector zero
    wr(3'd6, 8'h00);
    rd(3'd6, 8'h01, "R12 sector zero stored as one");
    wr(3'd6, 8'd5);
    rd(3'd6, 8'd5, "R12 sector write");
    wr(3'd5, 8'd3);
    rd(3'd5, 8'd3, "R1 track write");

    // R6 read sector track 3 sector 5
    wr(3'd4, 8'h8C);
    rd(3'd4, 8'h01, "R6 busy during fill");
    repeat (300) @(posedge clk);
    rd(3'd4, 8'h03, "R6 busy and drq after fill");
    rd(3'd0, 8'h40, "R3 drq mirror");
    for (int i = 0; i < 256; i++)
      rd(3'd7, pat(0, sect_addr(3, 5, i)), "R6 R10 sector byte");
    rd(3'd0, 8'h80, "R3 irq at end of transfer");
    rd(3'd4, 8'h00, "R8 flags clear at 256");
    rd(3'd0, 8'h00, "R3 irq cleared by status read");
    rd(3'd7, 8'h00, "R9 read past end");

    // R5 R7 R8 write sector track 3 sector 6
    wr(3'd6, 8'd6);
    wr(3'd4, 8'hAC);
    rd(3'd4, 8'h02, "R5 drq shown alone first");
    rd(3'd4, 8'h03, "R5 busy on second poll");
    for (int i = 0; i < 256; i++) wr(3'd7, 8'(i * 7 + 1));
    rd(3'd4, 8'h00, "R8 flags clear after write");
    repeat (300) @(posedge clk);
    check(wr_cnt, 256, "R8 commit byte count");
    wr(3'd4, 8'h9C);
    repeat (300) @(posedge clk);
    for (int i = 0; i < 256; i++)
      rd(3'd7, 8'(i * 7 + 1), "R8 committed byte readback");

    // R10 last sector of track 79
    wr(3'd5, 8'd79);
    wr(3'd6, 8'd72);
    wr(3'd4, 8'h8C);
    repeat (300) @(posedge clk);
    rd(3'd7, pat(0, sect_addr(79, 72, 0)), "R10 offset byte 0");
    rd(3'd7, pat(0, sect_addr(79, 72, 1)), "R10 offset byte 1");

    // R7 R13 protected drive 1
    wr(3'd0, 8'h01);
    rd(3'd4, 8'h40, "R4 write protect bit");
    rd(3'd5, 8'h00, "R13 drive 1 track separate");
    wr(3'd4, 8'hAC);
    rd(3'd4, 8'h40, "R7 write on protected drive ignored");
    rd(3'd7, 8'h00, "R7 no transfer opened");
    repeat (300) @(posedge clk);
    check(wr_cnt, 256, "R7 no storage write");
    wr(3'd5, 8'd9);
    wr(3'd0, 8'h00);
    rd(3'd5, 8'd79, "R13 drive 0 track kept");
    rd(3'd6, 8'd72, "R13 drive 0 sector kept");

    // R11 seek and restore
    wr(3'd7, 8'h2A);
    wr(3'd4, 8'h18);
    rd(3'd5, 8'h2A, "R11 seek 0x18");
    rd(3'd0, 8'h80, "R11 seek clears drq and raises irq");
    wr(3'd7, 8'h11);
    wr(3'd4, 8'h1B);
    rd(3'd5, 8'h11, "R11 seek 0x1B");
    wr(3'd4, 8'h0B);
    rd(3'd5, 8'h00, "R11 restore");

    // R14 unknown command
    wr(3'd5, 8'd5);
    wr(3'd4, 8'h55);
    rd(3'd5, 8'd5, "R14 unknown command track");
    rd(3'd4, 8'h00, "R14 unknown command status");

    // R14 drive without media
    wr(3'd0, 8'h03);
    rd(3'd4, 8'h80, "R14 not ready bit");
    wr(3'd5, 8'd7);
    wr(3'd7, 8'h20);
    wr(3'd4, 8'h18);
    rd(3'd5, 8'd7, "R14 seek ignored without media");
    wr(3'd4, 8'h8C);
    rd(3'd4, 8'h80, "R14 read ignored without media");

    // R2 side and motor
    wr(3'd0, 8'hC2);
    check(int'(side), 1, "R2 side set");
    check(int'(motor), 1, "R2 motor on");
    rd(3'd5, 8'h00, "R13 drive 2 track");
    repeat (120) @(posedge clk);
    check(int'(motor), 0, "R2 motor timed out");
    wr(3'd0, 8'h80);
    check(int'(motor), 1, "R2 motor retrigger");
    check(int'(side), 0, "R2 side cleared");

    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule